// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Shifter

This block is a byte-wide serial unit that acts as the clock master on a two-wire link. One pin carries a shift clock that the block always drives. The second pin is a single data line used in both directions. The block drives it while sending and releases it while receiving. A host writes bytes into a one-deep transmit holding register and reads received bytes from a one-deep receive buffer. Single-cycle pulses report when the holding register empties, when a byte has been sent, when a byte has arrived, and when an overrun occurs.

A run bit gates all activity. A programmable divider sets the shift-clock rate: each half of a shift-clock period lasts `baud_div + 1` clocks. Reception is one-shot. The host raises the receive enable, one byte is clocked in, and the enable drops by itself. Transmission is double-buffered. After every byte the line holds high for one full shift-clock period before the next byte may begin. A loopback mode feeds the transmit shifter into the receive shifter, so that a sent byte is captured as received data without using the data pin.

The controller has five states. ST_IDLE holds both lines high. ST_LOW is the low half of a bit, where the data line is updated. ST_HIGH is the high half of a bit, entered on the rising clock where the input is sampled. ST_GAP_A and ST_GAP_B form the inter-byte gap. The transitions are as follows:
- ST_IDLE to ST_LOW happens when a start is allowed.
- ST_LOW to ST_HIGH happens on a divider tick.
- ST_HIGH to ST_LOW happens on a tick for bits 0 to 6.
- ST_HIGH to ST_GAP_A happens on the tick that ends bit 7.
- ST_GAP_A to ST_GAP_B happens on a tick.
- ST_GAP_B goes to ST_LOW on a tick if another start is allowed, and to ST_IDLE otherwise.

Top module: `hdx_sync_serial`

## Requirements
- R1: After reset, `sclk_o` and `sdat_o` are 1, and `rxen`, `rxb_full` and `ovf_flag` are 0.
- R2: With `run_en`=1, `loop_en`=0 and `rxen`=0, a write to an idle unit makes `sclk_o` fall within 4 clocks after the write cycle.
- R3: Data bits go out least-significant bit first. `sdat_o` changes while `sclk_o` is low and is valid when `sclk_o` rises.
- R4: `irq_txbe` pulses once each time a byte moves from the holding register into the shifter. A byte written while another is shifting stays held, with no pulse, until the current byte and its gap end.
- R5: After the eighth bit, `sclk_o` and `sdat_o` are both 1 and `irq_txc` pulses once for each sent byte.
- R6: Between consecutive bytes, `sclk_o` stays high for one full shift-clock period (2*(`baud_div`+1) clocks) after the completion point that follows the eighth rising edge.
- R7: No byte starts while `run_en`=0. Outside loopback, no transmission starts while `rxen`=1, and a transmit write during a reception leaves the received byte intact.
- R8: Raising `rxen` with `run_en`=1 clocks in eight bits on rising edges of `sclk_o`, least-significant bit first. The byte goes to `rxb_rdata`, `rxb_full` goes to 1, `irq_rxc` pulses, and `rxen` returns to 0. No transmit-complete pulse occurs.
- R9: Clearing `rxen` during a reception still completes the byte and its `irq_rxc`.
- R10: With `ovchk_en`=1, a byte completing while `rxb_full`=1 sets `ovf_flag` and pulses `irq_err`. The flag stays set until `ovf_clr`. With `ovchk_en`=0 no flag or error is produced. `rxb_rd` clears `rxb_full`.
- R11: In loopback, a written byte does not start until `rxen`=1. It is then captured as received data.
- R12: Each half of a shift-clock period lasts `baud_div`+1 clocks.
- R13: `sdat_oe` is 0 while a byte is being received from the pin and while loopback is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Allows bytes to start |
| loop_en | input | 1 | Internal loopback of transmit into receive |
| ovchk_en | input | 1 | Enables overrun detection |
| baud_div | input | DIV_W | Half shift-clock period minus one, in clocks |
| rxen_set | input | 1 | Pulse: set receive enable |
| rxen_clr | input | 1 | Pulse: clear receive enable |
| rxen | output | 1 | Receive enable state |
| txb_wr | input | 1 | Transmit holding register write strobe |
| txb_wdata | input | DATA_W | Byte to transmit |
| rxb_rd | input | 1 | Receive buffer read strobe |
| rxb_rdata | output | DATA_W | Last received byte |
| rxb_full | output | 1 | Receive buffer holds an unread byte |
| ovf_clr | input | 1 | Clears the overrun flag |
| ovf_flag | output | 1 | Sticky overrun flag |
| irq_txbe | output | 1 | Pulse: holding register emptied |
| irq_txc | output | 1 | Pulse: byte sent |
| irq_rxc | output | 1 | Pulse: byte received |
| irq_err | output | 1 | Pulse: overrun |
| sclk_o | output | 1 | Shift clock, idles high |
| sdat_o | output | 1 | Data line output value |
| sdat_oe | output | 1 | Data line output enable |
| sdat_i | input | 1 | Data line input value |

## Verification
The hardest situation to reach is a transmit byte sitting in the holding register while a reception runs. It has to stay parked there without disturbing the incoming bits, and then launch only after the receive enable has cleared itself and the inter-byte gap has passed. The stimulus raises the receive enable first. It then writes a transmit byte a few clocks into the reception, while a bench slave drives the data line on each falling clock. The bench then checks the received byte, the absence of an early holding-register-empty pulse, and the later serialised transmit byte. Overrun is reached by leaving a byte unread and running a second reception, once with checking on and once with it off.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP_A,
        ST_GAP_B
    } seq_state_t;
endpackage

// File: rtl/hdx_baud.sv
module hdx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= '0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !hold && (cnt_q >= div);

    // R12: a half period never collapses below two clocks when div is non-zero
    assert_half_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);
endmodule

// File: rtl/hdx_txbuf.sv
module hdx_txbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              empty_pulse
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full        <= 1'b0;
            data        <= '0;
            empty_pulse <= 1'b0;
        end else begin
            empty_pulse <= take;
            if (wr) begin
                full <= 1'b1;
                data <= wdata;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    // R4: an empty indication only follows a cycle where a byte was held
    assert_txbe_from_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty_pulse |-> $past(full));
endmodule

// File: rtl/hdx_rxbuf.sv
module hdx_rxbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] ldata,
    input  logic              rd,
    input  logic              ovchk_en,
    input  logic              ov_clr,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ov_flag,
    output logic              done_pulse,
    output logic              err_pulse
);
    logic overrun;

    assign overrun = load && full && !rd && ovchk_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data       <= '0;
            full       <= 1'b0;
            ov_flag    <= 1'b0;
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            done_pulse <= load;
            err_pulse  <= overrun;
            if (load) begin
                data <= ldata;
                full <= 1'b1;
            end else if (rd) begin
                full <= 1'b0;
            end
            if (overrun) begin
                ov_flag <= 1'b1;
            end else if (ov_clr) begin
                ov_flag <= 1'b0;
            end
        end
    end

    // R10: overrun flag is sticky until cleared
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag && !ov_clr) |=> ov_flag);
    // R10: an error only arises when the buffer was already holding data
    assert_err_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($past(full) && done_pulse));
endmodule

// File: rtl/hdx_seq.sv
module hdx_seq
    import hdx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              loop,
    input  logic              rx_en,
    input  logic              tx_full,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [DIV_W-1:0]  div,
    input  logic              sdat_i,
    output logic              tx_take,
    output logic              rx_load,
    output logic [DATA_W-1:0] rx_word,
    output logic              txc_pulse,
    output logic              sclk,
    output logic              sdat_o,
    output logic              sdat_oe
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [DATA_W-1:0] txsh_q, rxsh_q;
    logic              op_tx_q, op_rx_q;
    logic              tick, want_tx, want_rx, start_ok, launch, byte_end, in_bit, busy;

    hdx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (state_q == ST_IDLE),
        .div  (div),
        .tick (tick)
    );

    assign want_tx  = tx_full && run && (loop ? rx_en : !rx_en);
    assign want_rx  = run && rx_en && !loop;
    assign start_ok = want_tx || want_rx;
    assign launch   = start_ok &&
                      ((state_q == ST_IDLE) || (state_q == ST_GAP_B && tick));
    assign tx_take  = launch && want_tx;
    assign byte_end = (state_q == ST_HIGH) && tick && (bit_idx_q == LAST_IDX);
    assign busy     = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign in_bit   = loop ? txsh_q[0] : sdat_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_LOW;
            ST_LOW:   if (tick) state_d = ST_HIGH;
            ST_HIGH:  if (tick) state_d = (bit_idx_q == LAST_IDX) ? ST_GAP_A : ST_LOW;
            ST_GAP_A: if (tick) state_d = ST_GAP_B;
            ST_GAP_B: if (tick) state_d = start_ok ? ST_LOW : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx_q <= '0;
            txsh_q    <= '1;
            rxsh_q    <= '0;
            op_tx_q   <= 1'b0;
            op_rx_q   <= 1'b0;
            txc_pulse <= 1'b0;
        end else begin
            txc_pulse <= byte_end && op_tx_q;
            if (launch) begin
                bit_idx_q <= '0;
                op_tx_q   <= want_tx;
                op_rx_q   <= loop ? want_tx : want_rx;
                txsh_q    <= want_tx ? tx_data : '1;
            end else if (state_q == ST_LOW && tick) begin
                rxsh_q <= {in_bit, rxsh_q[DATA_W-1:1]};
            end else if (state_q == ST_HIGH && tick && bit_idx_q != LAST_IDX) begin
                txsh_q    <= {1'b1, txsh_q[DATA_W-1:1]};
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        sclk    = (state_q != ST_LOW);
        sdat_o  = (busy && op_tx_q) ? txsh_q[0] : 1'b1;
        sdat_oe = !loop && !(busy && op_rx_q);
    end

    assign rx_load = byte_end && op_rx_q;
    assign rx_word = rxsh_q;

    // R5: both lines high right after the final bit
    assert_lines_high_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end |=> (sclk && sdat_o));
    // R7: nothing launches from idle without the run bit
    assert_no_start_without_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !run) |=> (state_q == ST_IDLE));
    // R7: receive enable blocks transmit outside loopback
    assert_rx_blocks_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop && rx_en) |-> !tx_take);
    // R6: the clock never falls straight out of the last bit
    assert_gap_before_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP_A) |=> sclk);
endmodule

// File: rtl/hdx_sync_serial.sv
module hdx_sync_serial #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              loop_en,
    input  logic              ovchk_en,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              rxen_set,
    input  logic              rxen_clr,
    output logic              rxen,
    input  logic              txb_wr,
    input  logic [DATA_W-1:0] txb_wdata,
    input  logic              rxb_rd,
    output logic [DATA_W-1:0] rxb_rdata,
    output logic              rxb_full,
    input  logic              ovf_clr,
    output logic              ovf_flag,
    output logic              irq_txbe,
    output logic              irq_txc,
    output logic              irq_rxc,
    output logic              irq_err,
    output logic              sclk_o,
    output logic              sdat_o,
    output logic              sdat_oe,
    input  logic              sdat_i
);
    logic              tx_full, tx_take, rx_load;
    logic [DATA_W-1:0] tx_data, rx_word;

    always_ff @(posedge clk) begin
        if (!rst_n)                   rxen <= 1'b0;
        else if (rxen_set)            rxen <= 1'b1;
        else if (rxen_clr || rx_load) rxen <= 1'b0;
    end

    hdx_txbuf #(.DATA_W(DATA_W)) u_txbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (txb_wr),
        .wdata      (txb_wdata),
        .take       (tx_take),
        .full       (tx_full),
        .data       (tx_data),
        .empty_pulse(irq_txbe)
    );

    hdx_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .loop     (loop_en),
        .rx_en    (rxen),
        .tx_full  (tx_full),
        .tx_data  (tx_data),
        .div      (baud_div),
        .sdat_i   (sdat_i),
        .tx_take  (tx_take),
        .rx_load  (rx_load),
        .rx_word  (rx_word),
        .txc_pulse(irq_txc),
        .sclk     (sclk_o),
        .sdat_o   (sdat_o),
        .sdat_oe  (sdat_oe)
    );

    hdx_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rx_load),
        .ldata     (rx_word),
        .rd        (rxb_rd),
        .ovchk_en  (ovchk_en),
        .ov_clr    (ovf_clr),
        .data      (rxb_rdata),
        .full      (rxb_full),
        .ov_flag   (ovf_flag),
        .done_pulse(irq_rxc),
        .err_pulse (irq_err)
    );

    // R8: receive enable has dropped by the time completion is reported
    assert_rxen_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxc |-> (!rxen || $past(rxen_set)));
endmodule

// File: tb/hdx_sync_serial_tb.sv
module hdx_sync_serial_tb;
    logic       clk = 0, rst_n = 0;
    logic       run_en = 0, loop_en = 0, ovchk_en = 0;
    logic [7:0] baud_div = 8'd3;
    logic       rxen_set = 0, rxen_clr = 0, txb_wr = 0, rxb_rd = 0, ovf_clr = 0, sdat_i = 1;
    logic [7:0] txb_wdata = 0;
    logic       rxen, rxb_full, ovf_flag, irq_txbe, irq_txc, irq_rxc, irq_err;
    logic       sclk_o, sdat_o, sdat_oe;
    logic [7:0] rxb_rdata;

    int n_chk = 0, n_fail = 0;
    int txbe_cnt = 0, txc_cnt = 0, rxc_cnt = 0, err_cnt = 0, fall_cnt = 0;
    logic [7:0] exp_q[$];
    logic [7:0] mon_byte = 0;
    int mon_bits = 0;
    logic prev_sclk = 1;
    logic gap_on = 0;
    int gap_cnt = 0, gap_meas = -1;
    logic [7:0] slv_byte = 0;
    int slv_idx = 0;

    always #2 clk = ~clk;

    hdx_sync_serial u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .loop_en(loop_en), .ovchk_en(ovchk_en),
        .baud_div(baud_div), .rxen_set(rxen_set), .rxen_clr(rxen_clr), .rxen(rxen),
        .txb_wr(txb_wr), .txb_wdata(txb_wdata), .rxb_rd(rxb_rd), .rxb_rdata(rxb_rdata),
        .rxb_full(rxb_full), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .irq_txbe(irq_txbe),
        .irq_txc(irq_txc), .irq_rxc(irq_rxc), .irq_err(irq_err), .sclk_o(sclk_o),
        .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: scoreboard for pin bytes, pulse counters, gap timing, and a bit-serving slave
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_txbe) txbe_cnt++;
            if (irq_txc)  txc_cnt++;
            if (irq_rxc)  rxc_cnt++;
            if (irq_err)  err_cnt++;
            if (prev_sclk && !sclk_o) begin
                fall_cnt++;
                sdat_i <= slv_byte[slv_idx[2:0]];
                slv_idx++;
            end
            if (sdat_oe && !prev_sclk && sclk_o) begin
                mon_byte[mon_bits] = sdat_o;
                mon_bits++;
                if (mon_bits == 8) begin
                    mon_bits = 0;
                    if (exp_q.size() == 0) chk(0, "R3 unexpected byte", mon_byte, -1);
                    else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(mon_byte == e, "R3 serial byte", mon_byte, e);
                    end
                end
            end
            if (irq_txc) begin
                gap_on = 1; gap_cnt = 0;
            end else if (gap_on) begin
                if (sclk_o) gap_cnt++;
                else begin gap_on = 0; gap_meas = gap_cnt; end
            end
            prev_sclk = sclk_o;
        end
    end

    task automatic write_tx(input logic [7:0] b, input bit on_pin);
        if (on_pin) exp_q.push_back(b);
        @(negedge clk); txb_wr = 1; txb_wdata = b;
        @(negedge clk); txb_wr = 0;
    endtask

    task automatic pulse_set();
        @(negedge clk); rxen_set = 1; @(negedge clk); rxen_set = 0;
    endtask

    task automatic read_rx();
        @(negedge clk); rxb_rd = 1; @(negedge clk); rxb_rd = 0;
    endtask

    task automatic wait_rxc(input int base);
        for (int i = 0; i < 400 && rxc_cnt <= base; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, lo, b0, b1, b2, b3, f0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(sclk_o == 1 && sdat_o == 1, "R1 lines idle high", {sclk_o, sdat_o}, 3);
        chk(rxen == 0 && rxb_full == 0 && ovf_flag == 0, "R1 flags clear",
            {rxen, rxb_full, ovf_flag}, 0);
        run_en = 1;

        // R2, R12, R3: start latency, half period length, one byte
        b0 = txbe_cnt; b1 = txc_cnt;
        write_tx(8'hA5, 1);
        n = 1;
        while (sclk_o && n < 10) begin @(negedge clk); n++; end
        chk(n <= 4, "R2 start latency", n, 4);
        lo = 0;
        while (!sclk_o && lo < 20) begin @(negedge clk); lo++; end
        chk(lo == 4, "R12 low half length", lo, 4);
        repeat (120) @(negedge clk);
        chk(txbe_cnt - b0 == 1, "R4 one empty pulse", txbe_cnt - b0, 1);
        chk(txc_cnt - b1 == 1, "R5 one complete pulse", txc_cnt - b1, 1);
        chk(sclk_o == 1 && sdat_o == 1, "R5 lines high after byte", {sclk_o, sdat_o}, 3);

        // R4, R6: double buffering and inter-byte gap
        b0 = txbe_cnt; b1 = txc_cnt;
        write_tx(8'h3C, 1);
        write_tx(8'h81, 1);
        repeat (8) @(negedge clk);
        chk(txbe_cnt - b0 == 1, "R4 second byte held", txbe_cnt - b0, 1);
        repeat (200) @(negedge clk);
        chk(txbe_cnt - b0 == 2, "R4 second byte taken", txbe_cnt - b0, 2);
        chk(txc_cnt - b1 == 2, "R5 two complete pulses", txc_cnt - b1, 2);
        // high seen on 2*(div+1)-1 negedges after the complete pulse sample
        chk(gap_meas == 7, "R6 gap length", gap_meas, 7);

        // R7: no start without run
        run_en = 0;
        f0 = fall_cnt; b0 = txbe_cnt;
        write_tx(8'h11, 1);
        repeat (50) @(negedge clk);
        chk(fall_cnt == f0 && txbe_cnt == b0, "R7 idle without run", fall_cnt - f0, 0);
        run_en = 1;
        repeat (120) @(negedge clk);
        chk(txbe_cnt - b0 == 1, "R7 starts once run set", txbe_cnt - b0, 1);

        // R8, R13: reception
        b1 = txc_cnt; b2 = rxc_cnt;
        slv_byte = 8'hC3; slv_idx = 0;
        pulse_set();
        repeat (10) @(negedge clk);
        chk(sdat_oe == 0, "R13 pin released in reception", sdat_oe, 0);
        wait_rxc(b2);
        @(negedge clk);
        chk(rxb_rdata == 8'hC3, "R8 received byte", rxb_rdata, 8'hC3);
        chk(rxen == 0 && rxb_full == 1, "R8 enable self-clears, buffer full",
            {rxen, rxb_full}, 1);
        chk(txc_cnt == b1, "R8 no transmit pulse", txc_cnt - b1, 0);
        read_rx();
        chk(rxb_full == 0, "R10 read clears full", rxb_full, 0);

        // R7: transmit write during reception
        b0 = txbe_cnt; b2 = rxc_cnt;
        slv_byte = 8'h96; slv_idx = 0;
        pulse_set();
        repeat (10) @(negedge clk);
        write_tx(8'h42, 1);
        repeat (20) @(negedge clk);
        chk(txbe_cnt == b0, "R7 no transmit during reception", txbe_cnt - b0, 0);
        wait_rxc(b2);
        @(negedge clk);
        chk(rxb_rdata == 8'h96, "R7 reception undisturbed", rxb_rdata, 8'h96);
        repeat (150) @(negedge clk);
        chk(txbe_cnt - b0 == 1, "R7 held byte sent afterwards", txbe_cnt - b0, 1);
        read_rx();

        // R9: clear enable mid-byte
        b2 = rxc_cnt;
        slv_byte = 8'h5B; slv_idx = 0;
        pulse_set();
        repeat (20) @(negedge clk);
        rxen_clr = 1; @(negedge clk); rxen_clr = 0;
        chk(rxen == 0, "R9 enable cleared", rxen, 0);
        wait_rxc(b2);
        @(negedge clk);
        chk(rxc_cnt - b2 == 1 && rxb_rdata == 8'h5B, "R9 byte completes", rxb_rdata, 8'h5B);

        // R10: overrun with checking enabled (buffer left unread)
        ovchk_en = 1;
        b2 = rxc_cnt; b3 = err_cnt;
        slv_byte = 8'hE7; slv_idx = 0;
        pulse_set();
        wait_rxc(b2);
        @(negedge clk);
        chk(ovf_flag == 1 && err_cnt - b3 == 1, "R10 overrun flagged", err_cnt - b3, 1);
        chk(rxb_rdata == 8'hE7, "R10 newest byte kept", rxb_rdata, 8'hE7);
        repeat (30) @(negedge clk);
        chk(ovf_flag == 1, "R10 flag sticky", ovf_flag, 1);
        @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        chk(ovf_flag == 0, "R10 flag cleared", ovf_flag, 0);
        ovchk_en = 0;
        b2 = rxc_cnt; b3 = err_cnt;
        slv_byte = 8'h18; slv_idx = 0;
        repeat (20) @(negedge clk);
        pulse_set();
        wait_rxc(b2);
        repeat (3) @(negedge clk);
        chk(ovf_flag == 0 && err_cnt == b3, "R10 no overrun when disabled", err_cnt - b3, 0);
        read_rx();

        // R11: loopback
        repeat (20) @(negedge clk);
        loop_en = 1;
        f0 = fall_cnt; b1 = txc_cnt; b2 = rxc_cnt;
        write_tx(8'h6D, 0);
        repeat (50) @(negedge clk);
        chk(fall_cnt == f0, "R11 waits for receive enable", fall_cnt - f0, 0);
        pulse_set();
        repeat (10) @(negedge clk);
        chk(sdat_oe == 0, "R13 pin released in loopback", sdat_oe, 0);
        wait_rxc(b2);
        @(negedge clk);
        chk(rxb_rdata == 8'h6D, "R11 looped byte captured", rxb_rdata, 8'h6D);
        chk(txc_cnt - b1 == 1 && rxen == 0, "R11 both completions", txc_cnt - b1, 1);
        loop_en = 0;

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all pin bytes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule